// File: doc/BRIEF.md
# Multi-Scope Reset Sequencer with Settle Timers

This block generates the reset and ready indications for a group of four serial transceiver channels and for the register core that sits beside them. Three kinds of request feed it. The first is an active-low hardware reset pin, which may be asynchronous. The second is one software reset bit per channel. The third is a single software reset bit that covers the whole channel group. Each request reaches its own set of scopes. The hardware pin clears the core and every channel. A software bit clears only transceiver channels and never touches the core.

The pin passes through a two-stage synchroniser. A low level is then honoured only when it persists for at least two host clocks. Each scope has its own settle timer. A scope's ready flag rises only after its request has stayed quiet for a full settle interval of `SETTLE_MS * CLK_PER_MS` host clocks, written D below. If a request returns while a timer is counting, the count starts again from zero. A synchronous active-high power-on input `por` puts the whole block into the same state as a hardware reset.

Top module: `rstc_scope_ctrl`

## Requirements
- R1: While `por` is high, `core_rst_o` and every bit of `chan_rst_o` are 1, and every ready output is 0. With the pin held high, ready rises at the (D+3)-th clock edge after `por` falls and is still 0 after D+2 edges.
- R2: A low level on `hw_rst_n` that is seen by only one clock edge is ignored. No reset output rises and no ready output falls.
- R3: A low level on `hw_rst_n` seen by two or more consecutive edges sets `core_rst_o` and all `chan_rst_o` bits to 1 from the fifth edge after the first low edge. It also clears every ready output.
- R4: After the pin returns high, the resets fall at the fourth edge that sees it high. `core_ready_o` and every `chan_ready_o` bit rise at edge D+3, and are 0 after D+2 edges.
- R5: Setting `chan_sw_rst[i]` raises `chan_rst_o[i]` and clears `chan_ready_o[i]` at the next edge. The other channels, `core_rst_o` and `core_ready_o` keep their values.
- R6: After `chan_sw_rst[i]` clears, `chan_ready_o[i]` rises at the D-th edge that sees it clear.
- R7: `blk_sw_rst` resets all channels, with the same timing as R5 and R6. `core_rst_o` stays 0 and `core_ready_o` stays 1.
- R8: A request that returns while a settle count is running restarts that count. Ready follows a full D edges after the last release.
- R9: No scope ever shows its reset and its ready flag high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| por | input | 1 | Synchronous active-high power-on reset |
| hw_rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| chan_sw_rst | input | NUM_CH | Per-channel software reset bits, active high |
| blk_sw_rst | input | 1 | Software reset for all channels, active high |
| core_rst_o | output | 1 | Reset to the core registers, active high |
| core_ready_o | output | 1 | Core settle interval complete |
| chan_rst_o | output | NUM_CH | Reset to each transceiver channel, active high |
| chan_ready_o | output | NUM_CH | Per-channel settle interval complete |

## Verification
One coincidence matters most. A qualified hardware reset can reach a channel timer in the cycle right after that channel's software bit was cleared. When that happens, the timer has just started a fresh count and must throw it away. The bench provokes this by holding one channel in software reset and pulling the pin low. It clears the software bit at the edge where the pin qualification completes, and releases the pin in the same step. The outcome is correct only if that channel stays not-ready until the hardware timing of R4 completes, well past the point where its software-only count would have finished.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  // Number of host clocks in a settle interval
  function automatic int unsigned settle_cycles(input int unsigned ms,
                                                input int unsigned per_ms);
    return ms * per_ms;
  endfunction

endpackage

// File: rtl/rstc_pin_qual.sv
// Synchronises the active-low reset pin and qualifies its minimum low width.
module rstc_pin_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_LOW     = 2
) (
  input  logic clk,
  input  logic por,
  input  logic pin_n,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] MIN_V = CW'(MIN_LOW);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          low_run;
  logic [CW-1:0]          low_run_nxt;
  logic                   sync_last;

  assign sync_last   = sync_q[SYNC_STAGES-1];
  assign low_run_nxt = (low_run == MIN_V) ? low_run : low_run + 1'b1;

  always_ff @(posedge clk) begin
    if (por) begin
      sync_q  <= '0;
      low_run <= MIN_V;
      qual_o  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      if (!sync_last) begin
        low_run <= low_run_nxt;
        qual_o  <= (low_run_nxt >= MIN_V);
      end else begin
        low_run <= '0;
        qual_o  <= 1'b0;
      end
    end
  end

  AST_SHORT_PULSE_IGNORED: assert property (@(posedge clk) disable iff (por)
    $rose(qual_o) |-> ($past(!sync_last, 1) && $past(!sync_last, 2))); // R2

  AST_QUAL_DROPS_ON_HIGH: assert property (@(posedge clk) disable iff (por)
    sync_last |=> !qual_o); // R4

endmodule

// File: rtl/rstc_settle_timer.sv
// One scope: registered reset follows the request, ready after a quiet interval.
module rstc_settle_timer #(
  parameter int unsigned SETTLE_CYC = 300000
) (
  input  logic clk,
  input  logic por,
  input  logic req,
  output logic rst_o,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (por) begin
      cnt     <= '0;
      rst_o   <= 1'b1;
      ready_o <= 1'b0;
    end else if (req) begin
      cnt     <= '0;
      rst_o   <= 1'b1;
      ready_o <= 1'b0;
    end else begin
      rst_o <= 1'b0;
      if (!ready_o) begin
        if (cnt == LAST) ready_o <= 1'b1;
        else             cnt     <= cnt + 1'b1;
      end
    end
  end

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (por)
    !(rst_o && ready_o)); // R9

  AST_REQ_RESTARTS: assert property (@(posedge clk) disable iff (por)
    req |=> (rst_o && !ready_o)); // R8

  AST_READY_AFTER_QUIET: assert property (@(posedge clk) disable iff (por)
    $rose(ready_o) |-> $past(!req)); // R6

endmodule

// File: rtl/rstc_scope_ctrl.sv
module rstc_scope_ctrl #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned CLK_PER_MS  = 100000,
  parameter int unsigned SETTLE_MS   = 3,
  parameter int unsigned MIN_LOW_CYC = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por,
  input  logic              hw_rst_n,
  input  logic [NUM_CH-1:0] chan_sw_rst,
  input  logic              blk_sw_rst,
  output logic              core_rst_o,
  output logic              core_ready_o,
  output logic [NUM_CH-1:0] chan_rst_o,
  output logic [NUM_CH-1:0] chan_ready_o
);
  import rstc_pkg::*;

  localparam int unsigned SETTLE_CYC = settle_cycles(SETTLE_MS, CLK_PER_MS);

  logic              hw_q;
  logic [NUM_CH-1:0] chan_req;

  rstc_pin_qual #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_LOW     (MIN_LOW_CYC)
  ) u_pin (
    .clk    (clk),
    .por    (por),
    .pin_n  (hw_rst_n),
    .qual_o (hw_q)
  );

  // Core scope: hardware source only
  rstc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_core (
    .clk     (clk),
    .por     (por),
    .req     (hw_q),
    .rst_o   (core_rst_o),
    .ready_o (core_ready_o)
  );

  // Channel scopes: hardware, block-wide software and own software bit
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    assign chan_req[i] = hw_q | blk_sw_rst | chan_sw_rst[i];

    rstc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
      .clk     (clk),
      .por     (por),
      .req     (chan_req[i]),
      .rst_o   (chan_rst_o[i]),
      .ready_o (chan_ready_o[i])
    );
  end

  AST_SW_SPARES_CORE: assert property (@(posedge clk) disable iff (por)
    ((blk_sw_rst || (|chan_sw_rst)) && !hw_q && core_ready_o) |=> core_ready_o); // R7

  AST_HW_HITS_ALL: assert property (@(posedge clk) disable iff (por)
    hw_q |=> ((&chan_rst_o) && core_rst_o && !core_ready_o)); // R3

endmodule

// File: tb/rstc_scope_ctrl_test.sv
`timescale 1ns/1ps
module rstc_scope_ctrl_test;
  localparam int NCH = 4;
  localparam int CPM = 10;
  localparam int SMS = 3;
  localparam int D   = CPM * SMS;

  logic           clk = 1'b0;
  logic           por;
  logic           hw_rst_n;
  logic [NCH-1:0] chan_sw_rst;
  logic           blk_sw_rst;
  logic           core_rst_o, core_ready_o;
  logic [NCH-1:0] chan_rst_o, chan_ready_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rstc_scope_ctrl #(
    .NUM_CH(NCH), .CLK_PER_MS(CPM), .SETTLE_MS(SMS),
    .MIN_LOW_CYC(2), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .por(por), .hw_rst_n(hw_rst_n),
    .chan_sw_rst(chan_sw_rst), .blk_sw_rst(blk_sw_rst),
    .core_rst_o(core_rst_o), .core_ready_o(core_ready_o),
    .chan_rst_o(chan_rst_o), .chan_ready_o(chan_ready_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Advance n edges, then sample 1 ns after the last one
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic all_state(input string req, input int rst, input int rdy);
    chk({req, " core_rst"},  core_rst_o,   rst);
    chk({req, " chan_rst"},  chan_rst_o,   rst ? 4'hF : 4'h0);
    chk({req, " core_rdy"},  core_ready_o, rdy);
    chk({req, " chan_rdy"},  chan_ready_o, rdy ? 4'hF : 4'h0);
  endtask

  task automatic t_por;
    por = 1'b1; hw_rst_n = 1'b1; chan_sw_rst = '0; blk_sw_rst = 1'b0;
    step(3);
    all_state("R1 in por", 1, 0);
    por = 1'b0;
    step(D + 2);
    all_state("R1 before settle", 0, 0);
    step(1);
    all_state("R1 settled", 0, 1);
  endtask

  task automatic t_short_pulse;
    hw_rst_n = 1'b0;
    step(1);
    hw_rst_n = 1'b1;
    step(8);
    all_state("R2 short pulse", 0, 1);
  endtask

  task automatic t_hw_min_pulse;
    hw_rst_n = 1'b0;
    step(2);
    hw_rst_n = 1'b1;
    step(3);
    all_state("R3 two-cycle pulse", 1, 0);
    step(D + 2);
    all_state("R3 recovered", 0, 1);
  endtask

  task automatic t_hw_release;
    hw_rst_n = 1'b0;
    step(8);
    all_state("R3 long low", 1, 0);
    hw_rst_n = 1'b1;
    step(3);
    chk("R4 rst held", core_rst_o, 1);
    step(1);
    chk("R4 rst falls", {core_rst_o, chan_rst_o}, 0);
    step(D - 2);
    all_state("R4 one short", 0, 0);
    step(1);
    all_state("R4 ready", 0, 1);
  endtask

  task automatic t_chan_sw;
    chan_sw_rst = 4'b0100;
    step(1);
    chk("R5 chan rst",  chan_rst_o,   4'b0100);
    chk("R5 chan rdy",  chan_ready_o, 4'b1011);
    chk("R5 core kept", {core_rst_o, core_ready_o}, 2'b01);
    step(5);
    chan_sw_rst = '0;
    step(D - 1);
    chk("R6 not yet", chan_ready_o, 4'b1011);
    chk("R6 rst low", chan_rst_o, 4'b0000);
    step(1);
    chk("R6 ready", chan_ready_o, 4'b1111);
  endtask

  task automatic t_blk_sw;
    blk_sw_rst = 1'b1;
    step(1);
    chk("R7 chan rst", chan_rst_o,   4'hF);
    chk("R7 chan rdy", chan_ready_o, 4'h0);
    chk("R7 core kept", {core_rst_o, core_ready_o}, 2'b01);
    step(4);
    blk_sw_rst = 1'b0;
    step(D - 1);
    chk("R7 not yet", chan_ready_o, 4'h0);
    chk("R7 core still", core_ready_o, 1);
    step(1);
    chk("R7 ready", chan_ready_o, 4'hF);
  endtask

  task automatic t_restart;
    chan_sw_rst = 4'b0010;
    step(1);
    chan_sw_rst = '0;
    step(10);
    chan_sw_rst = 4'b0010;
    step(1);
    chan_sw_rst = '0;
    step(D - 1);
    chk("R8 restarted", chan_ready_o, 4'b1101);
    step(1);
    chk("R8 ready", chan_ready_o, 4'b1111);
  endtask

  // Software release lands in the cycle the pin qualification completes
  task automatic t_coincide;
    chan_sw_rst = 4'b1000;
    step(2);
    hw_rst_n = 1'b0;
    step(3);
    chan_sw_rst = '0;
    hw_rst_n = 1'b1;
    step(D);
    chk("R8 coincide chan3 held", chan_ready_o, 4'h0);
    step(2);
    chk("R4 coincide not yet", {core_ready_o, chan_ready_o}, 5'h00);
    step(1);
    chk("R4 coincide ready", {core_ready_o, chan_ready_o}, 5'h1F);
    chk("R9 coincide rst low", {core_rst_o, chan_rst_o}, 5'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_por();
    t_short_pulse();
    t_hw_min_pulse();
    t_hw_release();
    t_chan_sw();
    t_blk_sw();
    t_restart();
    t_coincide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule